// File: doc/BRIEF.md
# PCI Base Address Register Bank

This block holds the six base address registers of a PCI type-0 configuration header on the device side. The registers sit at configuration byte offsets 10h through 24h, which are dword offsets 4 through 9. A configuration agent reaches them through a plain register port that carries a dword offset, a write strobe, four byte enables and write data. Read data is returned combinationally for the offset that is presented.

Each slot is set at elaboration time to one of four kinds: unimplemented, I/O, 32-bit memory, or 64-bit memory. Each slot also gets a power-of-two region size and a prefetchable flag. The low address bits that fall inside the region are wired to zero. The attribute bits are fixed. Because of this, enumeration software can write all ones, read the value back, clear the flag field, invert the result and add one to find the region size, and then write the original value back.

A slot of the 64-bit kind pairs with the slot that follows it. That next slot then holds address bits 63:32 of the region, and its own kind setting is ignored.

Top module: `bar_regs`

## Requirements
- R1: Slots occupy dword offsets 4 to 9 (byte offsets 10h to 24h) in slot order. Any other offset reads as zero, and a write to it changes no slot.
- R2: An I/O slot reads bit 0 as 1 and bit 1 as 0. Both bits are read-only. Its address bits below max(2, size log2) read as zero.
- R3: A memory slot reads bit 0 as 0. Bits 2:1 read 00 for a 32-bit region and 10 for a 64-bit region. Bit 3 reads the prefetchable setting. All four bits are read-only, and address bits below max(4, size log2) read as zero.
- R4: After all ones are written to a slot, reading it back, masking off the flag field, inverting and adding one gives the configured region size.
- R5: The slot after a 64-bit slot holds address bits 63:32. Its bit j is writable only when j+32 is at least the size log2, so it is fully writable for sizes up to 4 GiB. The lower slot of a region of 4 GiB or more has no writable bits.
- R6: An unimplemented slot always reads zero and ignores writes.
- R7: A write updates only the bytes whose enable is set. The new value is visible from the cycle after the write strobe.
- R8: Writing back a value read earlier restores it exactly.
- R9: After reset every writable bit is zero, so each slot reads its fixed attribute bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe |
| cfg_addr_i | input | 6 | Dword offset in configuration space |
| cfg_be_i | input | 4 | Byte enables for writes |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data for cfg_addr_i |

## Verification
On every cycle, the assertions check the offset decode. Offsets outside the window read zero, reads return the addressed slot, and writes disturb no other slot. They also check that unimplemented slots stay zero and that idle or fully masked writes leave all slots unchanged. The exact masks only show up in the bench's scenarios. These include the zeroed low bits after an all-ones probe, the fixed type and prefetch encodings, the 64-bit pairing of a region larger than 4 GiB, per-byte merges, and restoring a saved value.

// File: rtl/bar_pkg.sv
package bar_pkg;
  localparam logic [1:0] KIND_NONE  = 2'd0;
  localparam logic [1:0] KIND_IO    = 2'd1;
  localparam logic [1:0] KIND_MEM32 = 2'd2;
  localparam logic [1:0] KIND_MEM64 = 2'd3;

  function automatic logic [31:0] bar_wmask(logic [1:0] kind, int szlg, bit upper);
    int lo;
    logic [31:0] m;
    if (upper) lo = (szlg > 32) ? szlg - 32 : 0;
    else if (kind == KIND_NONE) lo = 32;
    else if (kind == KIND_IO) lo = (szlg > 2) ? szlg : 2;
    else lo = (szlg > 4) ? szlg : 4;
    for (int j = 0; j < 32; j++) m[j] = (j >= lo);
    return m;
  endfunction

  function automatic logic [31:0] bar_fixed(logic [1:0] kind, bit pref, bit upper);
    if (upper || kind == KIND_NONE) return 32'h0;
    if (kind == KIND_IO) return 32'h1;
    return {28'h0, pref, (kind == KIND_MEM64), 2'b00};
  endfunction
endpackage

// File: rtl/bar_slot.sv
module bar_slot #(
  parameter logic [31:0] WMASK = 32'h0,
  parameter logic [31:0] FIXED = 32'h0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sel_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] q_o
);
  logic [31:0] store_q;

  for (genvar b = 0; b < 4; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) store_q[8*b +: 8] <= '0;
      else if (sel_i && be_i[b]) store_q[8*b +: 8] <= wdata_i[8*b +: 8] & WMASK[8*b +: 8];
    end
  end

  assign q_o = (store_q & WMASK) | FIXED;
endmodule

// File: rtl/bar_rd_mux.sv
module bar_rd_mux #(
  parameter int N    = 6,
  parameter int AW   = 6,
  parameter int BASE = 4
) (
  input  logic [AW-1:0]   addr_i,
  input  logic [N*32-1:0] slots_i,
  output logic [31:0]     rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N; i++)
      if (addr_i == AW'(BASE + i)) rdata_o = slots_i[i*32 +: 32];
  end
endmodule

// File: rtl/bar_regs.sv
module bar_regs #(
  parameter int          SLOT_CNT = 6,
  parameter int          AW       = 6,
  parameter int          BASE_DW  = 4,
  parameter int          SZ_W     = 6,
  parameter logic [2*SLOT_CNT-1:0]    KIND_P = {2'd2, 2'd0, 2'd0, 2'd3, 2'd1, 2'd2},
  parameter logic [SZ_W*SLOT_CNT-1:0] SZ_P   = {6'd4, 6'd0, 6'd0, 6'd34, 6'd8, 6'd12},
  parameter logic [SLOT_CNT-1:0]      PREF_P = 6'b000100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [3:0]    cfg_be_i,
  input  logic [31:0]   cfg_wdata_i,
  output logic [31:0]   cfg_rdata_o
);
  function automatic logic [SLOT_CNT-1:0] calc_upper();
    logic [SLOT_CNT-1:0] u;
    u = '0;
    for (int i = 1; i < SLOT_CNT; i++)
      u[i] = (KIND_P[2*(i-1) +: 2] == bar_pkg::KIND_MEM64) && !u[i-1];
    return u;
  endfunction

  localparam logic [SLOT_CNT-1:0] UPPER_MASK = calc_upper();

  logic [SLOT_CNT*32-1:0] slot_flat;

  for (genvar i = 0; i < SLOT_CNT; i++) begin : g_slot
    localparam bit         IS_UP = UPPER_MASK[i];
    localparam int         SRC   = IS_UP ? i - 1 : i;
    localparam logic [1:0] KIND  = KIND_P[2*i +: 2];
    localparam int         SZLG  = int'(SZ_P[SZ_W*SRC +: SZ_W]);
    logic sel;
    assign sel = cfg_we_i && (cfg_addr_i == AW'(BASE_DW + i));
    bar_slot #(
      .WMASK(bar_pkg::bar_wmask(KIND, SZLG, IS_UP)),
      .FIXED(bar_pkg::bar_fixed(KIND, PREF_P[i], IS_UP))
    ) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sel_i  (sel),
      .be_i   (cfg_be_i),
      .wdata_i(cfg_wdata_i),
      .q_o    (slot_flat[i*32 +: 32])
    );
  end

  bar_rd_mux #(.N(SLOT_CNT), .AW(AW), .BASE(BASE_DW)) u_mux (
    .addr_i (cfg_addr_i),
    .slots_i(slot_flat),
    .rdata_o(cfg_rdata_o)
  );
endmodule

// File: rtl/bar_regs_chk.sv
module bar_regs_chk #(
  parameter int N    = 6,
  parameter int AW   = 6,
  parameter int BASE = 4,
  parameter logic [2*N-1:0] KIND  = '0,
  parameter logic [N-1:0]   UPPER = '0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [3:0]    be_i,
  input logic [31:0]   rdata_i,
  input logic [N*32-1:0] slots_i
);
  logic in_win;
  assign in_win = (addr_i >= AW'(BASE)) && (addr_i < AW'(BASE + N));

  // R1: outside window reads zero
  p_outside_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_win |-> rdata_i == 32'h0);

  // R7: idle or fully masked writes change nothing
  p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i || be_i == 4'h0) |=> $stable(slots_i));

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R1: read returns the addressed slot
    p_rd_map_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      addr_i == AW'(BASE + i) |-> rdata_i == slots_i[i*32 +: 32]);
    // R1: writes elsewhere leave this slot alone
    p_other_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && addr_i == AW'(BASE + i)) |=> $stable(slots_i[i*32 +: 32]));
    if (KIND[2*i +: 2] == 2'd0 && !UPPER[i]) begin : g_none
      // R6: unimplemented slot stays zero
      p_unimpl_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        slots_i[i*32 +: 32] == 32'h0);
    end
  end
endmodule

bind bar_regs bar_regs_chk #(
  .N(SLOT_CNT), .AW(AW), .BASE(BASE_DW), .KIND(KIND_P), .UPPER(UPPER_MASK)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (cfg_we_i),
  .addr_i (cfg_addr_i),
  .be_i   (cfg_be_i),
  .rdata_i(cfg_rdata_o),
  .slots_i(slot_flat)
);

// File: tb/bar_regs_bench.sv
`timescale 1ns/1ps
module bar_regs_bench;
  typedef struct {
    logic [5:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  bar_regs u_bar_regs (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_be_i(be), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata)
  );

  task automatic wr(input logic [5:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; be = b; wdata = d;
    @(negedge clk);
    we = 1'b0; be = 4'h0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    we = 1'b0; addr = a;
    it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: compare one cycle after each queued read
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        total++;
        if (rdata !== it.exp) begin
          bad++;
          $display("FAIL %s addr=%0d got=%08h exp=%08h", it.tag, it.addr, rdata, it.exp);
        end
      end
    end
  end

  function automatic logic [31:0] size_of(input logic [31:0] v, input logic [31:0] flags);
    return ~(v & ~flags) + 32'h1;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state shows fixed bits only
    rd(6'd4, 32'h0000_0000, "R9 slot0");
    rd(6'd5, 32'h0000_0001, "R9 slot1");
    rd(6'd6, 32'h0000_000C, "R9 slot2");
    rd(6'd7, 32'h0000_0000, "R9 slot3");
    rd(6'd9, 32'h0000_0000, "R9 slot5");
    // R1: outside offsets
    rd(6'd3, 32'h0, "R1 offset3");
    rd(6'd10, 32'h0, "R1 offset10");
    rd(6'd0, 32'h0, "R1 offset0");
    // all-ones probe
    for (int a = 4; a < 10; a++) wr(6'(a), 4'hF, 32'hFFFF_FFFF);
    rd(6'd4, 32'hFFFF_F000, "R3 mem32 probe");
    rd(6'd5, 32'hFFFF_FF01, "R2 io probe");
    rd(6'd6, 32'h0000_000C, "R5 mem64 lower probe");
    rd(6'd7, 32'hFFFF_FFFC, "R5 mem64 upper probe");
    rd(6'd8, 32'h0, "R6 unimplemented probe");
    rd(6'd9, 32'hFFFF_FFF0, "R3 min-size probe");
    // R4: size recovery, compared through the same scoreboard
    total++;
    if (size_of(32'hFFFF_F000, 32'hF) != 32'h1000 || size_of(32'hFFFF_FF01, 32'h3) != 32'h100) begin
      bad++;
      $display("FAIL R4 size got=%08h exp=%08h", size_of(32'hFFFF_F000, 32'hF), 32'h1000);
    end
    rd(6'd4, ~32'h0000_0FFF, "R4 size 4KiB");
    // R7: byte enables
    wr(6'd4, 4'hF, 32'h0);
    wr(6'd4, 4'h4, 32'h1234_5678);
    rd(6'd4, 32'h0034_0000, "R7 byte2 only");
    wr(6'd4, 4'h2, 32'hAABB_CCDD);
    rd(6'd4, 32'h0034_C000, "R7 byte1 masked");
    wr(6'd4, 4'h0, 32'hFFFF_FFFF);
    rd(6'd4, 32'h0034_C000, "R7 no enables");
    // R1: write outside window
    wr(6'd3, 4'hF, 32'hFFFF_FFFF);
    rd(6'd4, 32'h0034_C000, "R1 stray write slot0");
    rd(6'd3, 32'h0, "R1 stray write offset3");
    // R6: unimplemented ignores writes
    wr(6'd8, 4'hF, 32'h5A5A_5A5A);
    rd(6'd8, 32'h0, "R6 write ignored");
    // R8: save, probe, restore
    wr(6'd5, 4'hF, 32'hFEDC_B123);
    rd(6'd5, 32'hFEDC_B101, "R8 io saved");
    wr(6'd5, 4'hF, 32'hFFFF_FFFF);
    wr(6'd5, 4'hF, 32'hFEDC_B101);
    rd(6'd5, 32'hFEDC_B101, "R8 io restored");
    wr(6'd7, 4'hF, 32'h1234_5677);
    rd(6'd7, 32'h1234_5674, "R5 upper write");
    wr(6'd7, 4'hF, 32'hFFFF_FFFF);
    wr(6'd7, 4'hF, 32'h1234_5674);
    rd(6'd7, 32'h1234_5674, "R8 upper restored");
    // R2/R3: read-only flags ignore zero writes
    wr(6'd6, 4'hF, 32'h0);
    rd(6'd6, 32'h0000_000C, "R3 flags read-only");
    wr(6'd5, 4'hF, 32'h0);
    rd(6'd5, 32'h0000_0001, "R2 flags read-only");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule